// File: doc/BRIEF.md
# Keypad-Programmed Three-Channel PWM Dimmer

The block scans a 4x4 matrix keypad and turns debounced key presses into a colour setting for three PWM outputs (red, green, blue). It pulls one column low at a time and reads the row lines through a two-stage synchroniser. It then builds a snapshot of all sixteen keys once per full pass over the columns. A debouncer turns stable snapshots into single key events. A parser accepts only a framed entry: a star, six decimal digits, then a hash.

Each pair of digits is one channel's duty in percent, from 00 to 99, with red first, then green, then blue. All three duties change together, and only when a complete and valid entry ends. Any other key order leaves the running duties untouched. The three PWM channels share one prescaler and one 0..99 step counter, so they run at the same frequency and stay in phase.

Top module: `kp_rgb_pwm`

## Requirements
- R1: After reset all three duties are 0, every PWM output is low, the parser waits for a star, and `cols_o` is 4'b1110 (column 0 driven).
- R2: Exactly one column line is low at any time. The columns take turns in the order 0,1,2,3,0,..., and each is held for `COL_HOLD_CYC` cycles. A full pass therefore takes 4*`COL_HOLD_CYC` cycles.
- R3: Rows are active-low. The key at row r and column c has index r*4+c and maps to this layout: row 0 is 1 2 3 A, row 1 is 4 5 6 B, row 2 is 7 8 9 C, row 3 is * 0 # D.
- R4: A key produces an event only after it has been seen in `DEB_PASSES` (default 3) consecutive scan passes. A press that spans fewer passes produces no event.
- R5: A held key produces exactly one event. No further event occurs until a pass sees no key pressed.
- R6: The sequence star, d0..d5, hash sets red = 10*d0+d1, green = 10*d2+d3 and blue = 10*d4+d5.
- R7: A star at any point discards the partial entry and starts a new one.
- R8: Each of the following discards the entry and leaves all duties unchanged: a letter key, a hash before six digits have arrived, or a seventh digit. Digits and hashes that arrive while no entry is open are ignored.
- R9: All three duty registers load in the same clock cycle. No duty changes in any other cycle.
- R10: Each PWM period lasts 100*`PRESC_CYC` cycles, which is 500 Hz at the defaults with a 50 MHz clock. In each period a channel is high for duty*`PRESC_CYC` cycles.
- R11: A duty never exceeds 99, and the PWM step counter stays within 0..99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 50 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rows_i | input | 4 | Keypad row lines, active-low, asynchronous |
| cols_o | output | 4 | Keypad column drive, one line low at a time |
| rgb_pwm_o | output | 3 | PWM outputs: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The assertions assume that the row lines move only on the scale of whole column holds. They also assume that a key's row follows its column drive, so a snapshot never sees a partial or bouncing level inside the synchroniser window. The bench keeps to this by modelling the keypad as a combinational row-from-column path driven by at most one pressed key. It changes that key only at clock falling edges. Each press and release is held for several full passes. The only exception is one deliberately short press, which is still longer than a column hold.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned KP_LINES = 4;
  localparam int unsigned KP_KEYS  = KP_LINES * KP_LINES;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned PWM_STEPS = 100;
  localparam int unsigned DUTY_W   = $clog2(PWM_STEPS);
  localparam int unsigned NUM_DIG  = 2 * NUM_CH;

  typedef enum logic [1:0] {K_DIGIT, K_STAR, K_HASH, K_LETTER} key_kind_e;

  typedef struct packed {
    key_kind_e   kind;
    logic [3:0]  val;
  } key_info_t;

  function automatic key_info_t key_decode(input logic [3:0] idx);
    key_info_t k;
    k.kind = K_DIGIT;
    k.val  = 4'd0;
    unique case (idx)
      4'd0:  k.val = 4'd1;
      4'd1:  k.val = 4'd2;
      4'd2:  k.val = 4'd3;
      4'd4:  k.val = 4'd4;
      4'd5:  k.val = 4'd5;
      4'd6:  k.val = 4'd6;
      4'd8:  k.val = 4'd7;
      4'd9:  k.val = 4'd8;
      4'd10: k.val = 4'd9;
      4'd13: k.val = 4'd0;
      4'd12: k.kind = K_STAR;
      4'd14: k.kind = K_HASH;
      default: k.kind = K_LETTER;
    endcase
    return k;
  endfunction

  function automatic logic [DUTY_W-1:0] pair_to_duty(input logic [3:0] tens, input logic [3:0] ones);
    return DUTY_W'(tens) * DUTY_W'(10) + DUTY_W'(ones);
  endfunction
endpackage

// File: rtl/kp_scan.sv
module kp_scan import kp_pkg::*; #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [KP_LINES-1:0] rows_i,
  output logic [KP_LINES-1:0] cols_o,
  output logic [KP_KEYS-1:0]  keys_o,
  output logic               pass_o
);
  localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [HW-1:0]          hold_q;
  logic [1:0]             col_q;
  logic [KP_LINES-1:0]    row_s1_q, row_s2_q;
  logic [KP_KEYS-1:0]     acc_q, merged;
  logic                   hold_end;

  assign hold_end = (hold_q == HW'(HOLD_CYC - 1));
  assign cols_o   = ~(KP_LINES'(1) << col_q);

  always_comb begin
    merged = acc_q;
    for (int r = 0; r < KP_LINES; r++) merged[{r[1:0], col_q}] = ~row_s2_q[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_s1_q <= '1;
      row_s2_q <= '1;
    end else begin
      row_s1_q <= rows_i;
      row_s2_q <= row_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      col_q  <= '0;
      acc_q  <= '0;
      keys_o <= '0;
      pass_o <= 1'b0;
    end else begin
      pass_o <= 1'b0;
      if (hold_end) begin
        hold_q <= '0;
        col_q  <= col_q + 2'd1;
        if (col_q == 2'd3) begin
          keys_o <= merged;
          pass_o <= 1'b1;
          acc_q  <= '0;
        end else begin
          acc_q  <= merged;
        end
      end else begin
        hold_q <= hold_q + HW'(1);
      end
    end
  end

  // R2
  cols_one_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cols_o) == 1);
  // R2
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(col_q) |-> col_q == $past(col_q) + 2'd1);
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce import kp_pkg::*; #(
  parameter int unsigned PASSES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KP_KEYS-1:0] keys_i,
  input  logic              pass_i,
  output logic              key_vld_o,
  output logic [3:0]        key_idx_o
);
  localparam int unsigned CW = $clog2(PASSES + 1);

  logic [3:0]    cand_q, sel;
  logic [CW-1:0] cnt_q;
  logic          lock_q, any;

  function automatic logic [3:0] lowest(input logic [KP_KEYS-1:0] k);
    logic [3:0] r;
    r = '0;
    for (int i = KP_KEYS - 1; i >= 0; i--) if (k[i]) r = 4'(i);
    return r;
  endfunction

  assign any = |keys_i;
  assign sel = lowest(keys_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q    <= '0;
      cnt_q     <= '0;
      lock_q    <= 1'b0;
      key_vld_o <= 1'b0;
      key_idx_o <= '0;
    end else begin
      key_vld_o <= 1'b0;
      if (pass_i) begin
        if (!any) begin
          lock_q <= 1'b0;
          cnt_q  <= '0;
        end else if (!lock_q) begin
          if (cnt_q != '0 && sel == cand_q) begin
            if (cnt_q == CW'(PASSES - 1)) begin
              key_vld_o <= 1'b1;
              key_idx_o <= sel;
              lock_q    <= 1'b1;
              cnt_q     <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end else begin
            cand_q <= sel;
            cnt_q  <= CW'(1);
          end
        end
      end
    end
  end

  // R4
  event_after_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_o |-> $past(pass_i));
  // R5
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_q) && lock_q) |-> !key_vld_o);
  // R5
  event_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_vld_o |-> lock_q);
endmodule

// File: rtl/kp_parse.sv
module kp_parse import kp_pkg::*; (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          key_vld_i,
  input  logic [3:0]                    key_idx_i,
  output logic [NUM_CH-1:0][DUTY_W-1:0] duty_o,
  output logic                          commit_o
);
  typedef enum logic {PS_IDLE, PS_ENTRY} pstate_e;

  localparam int unsigned NW = $clog2(NUM_DIG + 1);

  pstate_e       state_q;
  logic [NW-1:0] cnt_q;
  logic [3:0]    dig_q [NUM_DIG];
  key_info_t     ki;

  assign ki = key_decode(key_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PS_IDLE;
      cnt_q    <= '0;
      duty_o   <= '0;
      commit_o <= 1'b0;
      for (int i = 0; i < NUM_DIG; i++) dig_q[i] <= '0;
    end else begin
      commit_o <= 1'b0;
      if (key_vld_i) begin
        unique case (ki.kind)
          K_STAR: begin
            state_q <= PS_ENTRY;
            cnt_q   <= '0;
          end
          K_DIGIT: begin
            if (state_q == PS_ENTRY) begin
              if (cnt_q < NW'(NUM_DIG)) begin
                for (int i = 0; i < NUM_DIG; i++)
                  if (cnt_q == NW'(i)) dig_q[i] <= ki.val;
                cnt_q <= cnt_q + NW'(1);
              end else begin
                state_q <= PS_IDLE;
              end
            end
          end
          K_HASH: begin
            if (state_q == PS_ENTRY && cnt_q == NW'(NUM_DIG)) begin
              for (int c = 0; c < NUM_CH; c++)
                duty_o[c] <= pair_to_duty(dig_q[2*c], dig_q[2*c+1]);
              commit_o <= 1'b1;
            end
            state_q <= PS_IDLE;
          end
          default: state_q <= PS_IDLE;
        endcase
      end
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R11
      duty_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        duty_o[c] < DUTY_W'(PWM_STEPS));
    end
  endgenerate

  // R9
  duty_only_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable(duty_o));
  // R6
  commit_from_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(key_vld_i) && $past(state_q) == PS_ENTRY);
  // R8
  digit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(NUM_DIG));
endmodule

// File: rtl/kp_pwm_bank.sv
module kp_pwm_bank import kp_pkg::*; #(
  parameter int unsigned PRESC = 1000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0][DUTY_W-1:0] duty_i,
  output logic [NUM_CH-1:0]             pwm_o
);
  localparam int unsigned PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0]     pre_q;
  logic [DUTY_W-1:0] step_q;
  logic              tick;

  assign tick = (pre_q == PW'(PRESC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      step_q <= (step_q == DUTY_W'(PWM_STEPS - 1)) ? '0 : step_q + DUTY_W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pwm_o[c] <= 1'b0;
        else         pwm_o[c] <= (step_q < duty_i[c]);
      end
      // R10
      zero_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_o[c] |-> $past(duty_i[c]) != '0);
    end
  endgenerate

  // R11
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < DUTY_W'(PWM_STEPS));
endmodule

// File: rtl/kp_rgb_pwm.sv
module kp_rgb_pwm import kp_pkg::*; #(
  parameter int unsigned COL_HOLD_CYC = 50000,
  parameter int unsigned DEB_PASSES   = 3,
  parameter int unsigned PRESC_CYC    = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  rows_i,
  output logic [3:0]  cols_o,
  output logic [2:0]  rgb_pwm_o
);
  logic [KP_KEYS-1:0]             keys;
  logic                           pass;
  logic                           key_vld;
  logic [3:0]                     key_idx;
  logic [NUM_CH-1:0][DUTY_W-1:0]  duty;
  logic                           commit;

  kp_scan #(.HOLD_CYC(COL_HOLD_CYC)) u_scan (
    .clk_i, .rst_ni, .rows_i, .cols_o, .keys_o(keys), .pass_o(pass)
  );

  kp_debounce #(.PASSES(DEB_PASSES)) u_deb (
    .clk_i, .rst_ni, .keys_i(keys), .pass_i(pass),
    .key_vld_o(key_vld), .key_idx_o(key_idx)
  );

  kp_parse u_parse (
    .clk_i, .rst_ni, .key_vld_i(key_vld), .key_idx_i(key_idx),
    .duty_o(duty), .commit_o(commit)
  );

  kp_pwm_bank #(.PRESC(PRESC_CYC)) u_pwm (
    .clk_i, .rst_ni, .duty_i(duty), .pwm_o(rgb_pwm_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> rgb_pwm_o == 3'b000 && cols_o == 4'b1110);
  // R9
  commit_sparse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit);
endmodule

// File: tb/kp_rgb_pwm_test.sv
module kp_rgb_pwm_test;
  localparam int HOLD  = 8;
  localparam int DEB   = 3;
  localparam int PRESC = 2;
  localparam int PASS  = 4 * HOLD;
  localparam int PER   = 100 * PRESC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rows;
  logic [3:0] cols;
  logic [2:0] pwm;
  int         key_r = -1;
  int         key_c = -1;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  kp_rgb_pwm #(.COL_HOLD_CYC(HOLD), .DEB_PASSES(DEB), .PRESC_CYC(PRESC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rows_i(rows), .cols_o(cols), .rgb_pwm_o(pwm)
  );

  always_comb begin
    rows = 4'hF;
    if (key_r >= 0 && key_c >= 0 && cols[key_c] == 1'b0) rows[key_r] = 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int key_index(input byte ch);
    case (ch)
      "1": return 0;  "2": return 1;  "3": return 2;  "A": return 3;
      "4": return 4;  "5": return 5;  "6": return 6;  "B": return 7;
      "7": return 8;  "8": return 9;  "9": return 10; "C": return 11;
      "*": return 12; "0": return 13; "#": return 14; default: return 15;
    endcase
  endfunction

  task automatic press(input byte ch, input int hold_cyc);
    int idx;
    idx = key_index(ch);
    @(negedge clk);
    key_r = idx / 4;
    key_c = idx % 4;
    repeat (hold_cyc) @(negedge clk);
    key_r = -1;
    key_c = -1;
    repeat (3 * PASS) @(negedge clk);
  endtask

  task automatic enter(input string s);
    for (int i = 0; i < s.len(); i++) press(s[i], 6 * PASS);
  endtask

  task automatic check_duties(input string req, input int r, input int g, input int b);
    int hi [3];
    repeat (PER) @(negedge clk);
    for (int c = 0; c < 3; c++) hi[c] = 0;
    for (int t = 0; t < PER; t++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) if (pwm[c]) hi[c]++;
    end
    check({req, " red"},   hi[0], r * PRESC);
    check({req, " green"}, hi[1], g * PRESC);
    check({req, " blue"},  hi[2], b * PRESC);
  endtask

  task automatic t_reset_and_scan();
    @(negedge clk);
    check("R1 cols at reset", int'(cols), 4'b1110);
    check("R1 pwm at reset", int'(pwm), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 2 * PASS; k++) begin
      @(negedge clk);
      check("R2 column sequence", int'(cols), int'(~(4'b0001 << ((k / HOLD) % 4)) & 4'hF));
    end
    check_duties("R1 duties zero", 0, 0, 0);
  endtask

  task automatic t_basic();
    enter("*250050#");
    check_duties("R6 R3 R10 basic entry", 25, 0, 50);
  endtask

  task automatic t_extremes();
    enter("*990199#");
    check_duties("R11 R9 extreme values", 99, 1, 99);
  endtask

  task automatic t_early_hash();
    enter("*1234#");
    check_duties("R8 early hash", 99, 1, 99);
  endtask

  task automatic t_letter();
    enter("*12A3456#");
    check_duties("R8 letter discards", 99, 1, 99);
    enter("123456#");
    check_duties("R8 no star ignored", 99, 1, 99);
  endtask

  task automatic t_seventh();
    enter("*1234567#");
    check_duties("R8 seventh digit", 99, 1, 99);
  endtask

  task automatic t_restart();
    enter("*12*334455#");
    check_duties("R7 star restarts", 33, 44, 55);
  endtask

  task automatic t_short();
    enter("*1122");
    press("3", PASS + PASS / 2);
    enter("33#");
    check_duties("R4 short press ignored", 11, 22, 33);
  endtask

  task automatic t_held();
    enter("*66778");
    press("9", 20 * PASS);
    enter("#");
    check_duties("R5 held key one event", 66, 77, 89);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_scan();
    t_basic();
    t_extremes();
    t_early_hash();
    t_letter();
    t_seventh();
    t_restart();
    t_short();
    t_held();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule